// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Per-Word Valid Tracking

This block sits between a 32-bit processor's instruction fetch port and a simple word-wide memory port. One aligned, power-of-two address window, set by a base/high parameter pair, is cacheable. Fetches that fall inside it are looked up in a direct-mapped store. Fetches that fall outside it go straight to memory and are never kept. Illegal parameter choices stop elaboration. These are a window that is not a power of two or not aligned to its size, a capacity outside 64 B to 64 KiB, a line length other than 4, 8 or 16 words, and a cache no smaller than the window.

Each line entry holds a tag, one valid bit for every word and a line-valid bit. The tag covers only the address bits inside the window that lie above the cache bits. On a miss the block first requests the word being fetched and hands it to the processor as it arrives. It then requests the other words of the line, marking each word valid as it is written. An invalidate input clears every entry with a sweep of one entry per cycle, and the fetch port is held off while the sweep runs.

Top module: `icache_dm`

## Requirements
- R1: An address A is cacheable exactly when BASE_ADDR <= A <= HIGH_ADDR. Any other fetch issues one memory request for A itself and returns its data. It allocates nothing, so fetching the same address again goes to memory again.
- R2: A fetch hits when the stored tag matches, the line-valid bit is set and the fetched word's valid bit is set. On a hit, resp_valid is high in the cycle right after the fetch is accepted, the cached word is returned and no memory request is made.
- R3: On a cacheable miss, the first memory request is for the fetched word. Its data appears on resp_data with resp_valid in the same cycle that mem_resp_valid brings it.
- R4: After the critical word, the block requests the other LINE_WORDS-1 words of the line. The word offset rises from the critical word and wraps modulo LINE_WORDS, so every line fill makes exactly LINE_WORDS requests. Once the fill is done, every word of the line hits.
- R5: A miss that maps to a line already holding a different tag replaces it. The line's word-valid bits are cleared in the same edge that writes the new tag and sets line-valid. A later fetch of the old address misses.
- R6: A one-cycle pulse on inv_all seen while idle holds fetch_ready low for exactly LINES+1 cycles, where LINES = CACHE_BYTES/(4*LINE_WORDS). After that, every cacheable fetch misses.
- R7: At most one fetch is outstanding. fetch_ready is low from acceptance until the response and the end of any fill, and each accepted fetch gets exactly one resp_valid cycle.
- R8: Once mem_req_valid is high it stays high, with mem_req_addr unchanged, until a cycle in which mem_req_ready is high.
- R9: After reset, fetch_ready is 1 and resp_valid and mem_req_valid are 0. All lines start invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Pulse requesting that every line be invalidated |
| fetch_valid | input | 1 | Processor presents a fetch address |
| fetch_ready | output | 1 | Block accepts a fetch in this cycle |
| fetch_addr | input | 32 | Byte address of the instruction word |
| resp_valid | output | 1 | Instruction word valid on resp_data (one cycle) |
| resp_data | output | 32 | Returned instruction word |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Word-aligned (cacheable) or exact (bypass) address |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | 32 | Memory read data |

## Verification
The hardest case to reach from the ports is a critical word that lies in the middle of a line. Its fill must wrap past the line end, and the miss must also evict a line holding another tag. Random addresses are drawn from three tags that share the same indexes, with random word offsets, so mid-line misses and evictions happen often. The memory model varies both request acceptance and response latency at random. This shows the fill order and the request hold hold up under back-pressure, and a bench model of tags and valid bits predicts hit, miss or bypass for every fetch.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_MREQ,
        ST_MWAIT,
        ST_SWEEP
    } ic_state_e;

endpackage

// File: rtl/icache_tagstore.sv
module icache_tagstore #(
    parameter int LINES      = 128,
    parameter int TAG_W      = 4,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINES),
    localparam int OFF_W     = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [TAG_W-1:0]      rd_tag,
    output logic                  rd_line_ok,
    output logic [LINE_WORDS-1:0] rd_word_ok,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  alloc_en,
    input  logic [TAG_W-1:0]      alloc_tag,
    input  logic                  setw_en,
    input  logic [OFF_W-1:0]      setw_word,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx
);

    logic [TAG_W-1:0]      tag_q  [LINES];
    logic                  line_q [LINES];
    logic [LINE_WORDS-1:0] word_q [LINES];

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            tag_q[wr_idx] <= alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                line_q[i] <= 1'b0;
                word_q[i] <= '0;
            end
        end else begin
            if (clr_en) begin
                line_q[clr_idx] <= 1'b0;
                word_q[clr_idx] <= '0;
            end
            if (alloc_en) begin
                line_q[wr_idx] <= 1'b1;
                word_q[wr_idx] <= '0;
            end
            if (setw_en) begin
                word_q[wr_idx][setw_word] <= 1'b1;
            end
        end
    end

    assign rd_tag     = tag_q[rd_idx];
    assign rd_line_ok = line_q[rd_idx];
    assign rd_word_ok = word_q[rd_idx];

endmodule

// File: rtl/icache_datastore.sv
module icache_datastore #(
    parameter int WORDS    = 1024,
    localparam int AW      = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/icache_dm.sv
module icache_dm
    import icache_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0030_0000,
    parameter logic [31:0] HIGH_ADDR   = 32'h0030_FFFF,
    parameter int          CACHE_BYTES = 4096,
    parameter int          LINE_WORDS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inv_all,
    input  logic        fetch_valid,
    output logic        fetch_ready,
    input  logic [31:0] fetch_addr,
    output logic        resp_valid,
    output logic [31:0] resp_data,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_resp_valid,
    input  logic [31:0] mem_resp_data
);

    localparam logic [32:0] WIN_SIZE = {1'b0, HIGH_ADDR} - {1'b0, BASE_ADDR} + 33'd1;
    localparam int WIN_BITS   = $clog2(WIN_SIZE);
    localparam int CACHE_BITS = $clog2(CACHE_BYTES);
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int WADDR_W    = CACHE_BITS - 2;
    localparam int IDX_W      = WADDR_W - OFF_W;
    localparam int TAG_W      = WIN_BITS - CACHE_BITS;
    localparam int LINES      = 1 << IDX_W;
    localparam int WORDS      = CACHE_BYTES / 4;

    // Parameter legality, checked while elaborating
    if ((WIN_SIZE & (WIN_SIZE - 33'd1)) != 33'd0 || WIN_BITS > 32) begin : g_bad_window
        $error("cacheable window must be a power of two no larger than 4 GiB");
    end
    if (({1'b0, BASE_ADDR} & (WIN_SIZE - 33'd1)) != 33'd0) begin : g_bad_base
        $error("window base must be aligned to the window size");
    end
    if (CACHE_BYTES < 64 || CACHE_BYTES > 65536 || (CACHE_BYTES & (CACHE_BYTES - 1)) != 0) begin : g_bad_size
        $error("cache size must be a power of two from 64 B to 64 KiB");
    end
    if (LINE_WORDS != 4 && LINE_WORDS != 8 && LINE_WORDS != 16) begin : g_bad_line
        $error("line length must be 4, 8 or 16 words");
    end
    if (TAG_W < 1 || IDX_W < 1) begin : g_bad_tag
        $error("window must exceed the cache and the cache must hold two lines");
    end

    typedef struct packed {
        ic_state_e        st;
        logic [31:0]      addr;
        logic [OFF_W-1:0] woff;
        logic [OFF_W-1:0] left;
        logic             crit;
        logic             byp;
        logic             inv_pend;
        logic [IDX_W-1:0] sweep;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [IDX_W-1:0]      idx_q;
    logic [OFF_W-1:0]      off_q;
    logic [TAG_W-1:0]      tag_in_q;
    logic [TAG_W-1:0]      st_tag;
    logic                  st_line_ok;
    logic [LINE_WORDS-1:0] st_word_ok;
    logic [31:0]           st_data;
    logic                  in_win, tag_ok, hit;
    logic                  alloc_en, setw_en, clr_en, dwe;

    // Signals observed by the bound checker
    logic sweeping, byp_active, store_wr;

    assign idx_q    = r_q.addr[CACHE_BITS-1:2+OFF_W];
    assign off_q    = r_q.addr[2+OFF_W-1:2];
    assign tag_in_q = r_q.addr[WIN_BITS-1:CACHE_BITS];
    assign in_win   = (r_q.addr >= BASE_ADDR) && (r_q.addr <= HIGH_ADDR);
    assign tag_ok   = st_line_ok && (st_tag == tag_in_q);
    assign hit      = in_win && tag_ok && st_word_ok[off_q];

    always_comb begin
        r_d           = r_q;
        fetch_ready   = 1'b0;
        resp_valid    = 1'b0;
        resp_data     = st_data;
        mem_req_valid = 1'b0;
        mem_req_addr  = r_q.byp ? r_q.addr
                                : {r_q.addr[31:2+OFF_W], r_q.woff, 2'b00};
        alloc_en      = 1'b0;
        setw_en       = 1'b0;
        clr_en        = 1'b0;
        dwe           = 1'b0;

        if (inv_all) begin
            r_d.inv_pend = 1'b1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.inv_pend) begin
                    r_d.st       = ST_SWEEP;
                    r_d.sweep    = '0;
                    r_d.inv_pend = inv_all;
                end else begin
                    fetch_ready = 1'b1;
                    if (fetch_valid) begin
                        r_d.addr = fetch_addr;
                        r_d.st   = ST_LOOKUP;
                    end
                end
            end
            ST_LOOKUP: begin
                if (!in_win) begin
                    r_d.byp = 1'b1;
                    r_d.st  = ST_MREQ;
                end else if (hit) begin
                    resp_valid = 1'b1;
                    resp_data  = st_data;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.byp  = 1'b0;
                    r_d.woff = off_q;
                    r_d.left = OFF_W'(LINE_WORDS - 1);
                    r_d.crit = 1'b1;
                    r_d.st   = ST_MREQ;
                    alloc_en = !tag_ok;
                end
            end
            ST_MREQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    r_d.st = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                if (mem_resp_valid) begin
                    if (r_q.byp) begin
                        resp_valid = 1'b1;
                        resp_data  = mem_resp_data;
                        r_d.byp    = 1'b0;
                        r_d.st     = ST_IDLE;
                    end else begin
                        dwe      = 1'b1;
                        setw_en  = 1'b1;
                        r_d.crit = 1'b0;
                        if (r_q.crit) begin
                            resp_valid = 1'b1;
                            resp_data  = mem_resp_data;
                        end
                        if (r_q.left == '0) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.left = r_q.left - 1'b1;
                            r_d.woff = r_q.woff + 1'b1;
                            r_d.st   = ST_MREQ;
                        end
                    end
                end
            end
            ST_SWEEP: begin
                clr_en    = 1'b1;
                r_d.sweep = r_q.sweep + 1'b1;
                if (r_q.sweep == IDX_W'(LINES - 1)) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sweeping   = (r_q.st == ST_SWEEP);
    assign byp_active = r_q.byp;
    assign store_wr   = alloc_en | setw_en | dwe;

    icache_tagstore #(
        .LINES      (LINES),
        .TAG_W      (TAG_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (idx_q),
        .rd_tag     (st_tag),
        .rd_line_ok (st_line_ok),
        .rd_word_ok (st_word_ok),
        .wr_idx     (idx_q),
        .alloc_en   (alloc_en),
        .alloc_tag  (tag_in_q),
        .setw_en    (setw_en),
        .setw_word  (r_q.woff),
        .clr_en     (clr_en),
        .clr_idx    (r_q.sweep)
    );

    icache_datastore #(
        .WORDS (WORDS)
    ) u_data (
        .clk   (clk),
        .we    (dwe),
        .waddr ({idx_q, r_q.woff}),
        .wdata (mem_resp_data),
        .raddr (r_q.addr[CACHE_BITS-1:2]),
        .rdata (st_data)
    );

endmodule

// File: rtl/icache_dm_chk.sv
module icache_dm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_valid,
    input logic        fetch_ready,
    input logic        resp_valid,
    input logic [31:0] resp_data,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_resp_valid,
    input logic [31:0] mem_resp_data,
    input logic        sweeping,
    input logic        byp_active,
    input logic        store_wr
);

    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (fetch_valid && fetch_ready) begin
            outst_q <= 1'b1;
        end else if (resp_valid) begin
            outst_q <= 1'b0;
        end
    end

    // R2: a response without memory data must follow an acceptance by one cycle
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !mem_resp_valid) |-> $past(fetch_valid && fetch_ready));

    // R3: a response that coincides with memory data forwards that data
    a_r3_miss_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && mem_resp_valid) |-> (resp_data == mem_resp_data));

    // R7: single outstanding fetch
    a_r7_accept_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready) |-> !outst_q);
    a_r7_resp_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> outst_q);
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !fetch_ready);

    // R8: a request is held with a stable address until taken
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: the port stays closed during the invalidate sweep
    a_r6_sweep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> !fetch_ready);

    // R1: a bypassed fetch never writes the stores
    a_r1_bypass_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        byp_active |-> !store_wr);

endmodule

bind icache_dm icache_dm_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_ready    (fetch_ready),
    .resp_valid     (resp_valid),
    .resp_data      (resp_data),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .sweeping       (sweeping),
    .byp_active     (byp_active),
    .store_wr       (store_wr)
);

// File: tb/tb_icache_dm.sv
module tb_icache_dm;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0030_0000;
    localparam logic [31:0] HIGH       = 32'h0030_FFFF;
    localparam int          CB         = 1024;
    localparam int          LW         = 8;
    localparam int          LINES      = CB / (4 * LW);
    localparam int          OFFW       = 3;
    localparam int          CBITS      = 10;
    localparam int          TAGW       = 16 - CBITS;
    localparam int          LOGN       = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, resp_valid, mem_req_valid;
    logic [31:0] resp_data, mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] req_log [LOGN];
    int          req_cnt = 0;
    bit          ref_ok  [LINES];
    int          ref_tag [LINES];

    always #(CLK_PERIOD / 2) clk = ~clk;

    icache_dm #(
        .BASE_ADDR   (BASE),
        .HIGH_ADDR   (HIGH),
        .CACHE_BYTES (CB),
        .LINE_WORDS  (LW)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .inv_all        (inv_all),
        .fetch_valid    (fetch_valid),
        .fetch_ready    (fetch_ready),
        .fetch_addr     (fetch_addr),
        .resp_valid     (resp_valid),
        .resp_data      (resp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data)
    );

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return {a[7:0], a[31:8]} ^ 32'h5A5A_C3C3;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: random acceptance, 1..3 cycle latency, R8 hold check
    bit          pend = 0, hold = 0;
    int          lat = 0;
    logic [31:0] paddr = '0, hold_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready  <= 1'b0;
            mem_resp_valid <= 1'b0;
            pend = 0;
            hold = 0;
        end else begin
            if (hold) begin
                check(mem_req_valid && mem_req_addr == hold_addr, "R8 request held", mem_req_addr, hold_addr);
            end
            hold      = mem_req_valid && !mem_req_ready;
            hold_addr = mem_req_addr;
            mem_resp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                req_log[req_cnt % LOGN] = mem_req_addr;
                req_cnt++;
                pend  = 1;
                lat   = 1 + int'($urandom % 3);
                paddr = mem_req_addr;
                mem_req_ready <= 1'b0;
            end else if (pend) begin
                lat--;
                if (lat == 0) begin
                    mem_resp_valid <= 1'b1;
                    mem_resp_data  <= memfn(paddr);
                    pend = 0;
                end
            end else begin
                mem_req_ready <= ($urandom % 4) != 0;
            end
        end
    end

    // kind: 0 hit, 1 miss, 2 bypass; want = -1 accepts the model's prediction
    task automatic do_fetch(input logic [31:0] a, input int want);
        int          kind, start, lat_c, extra, delta, idx, tg, off;
        logic [31:0] got, lbase;
        bit          in_win;
        in_win = (a >= BASE) && (a <= HIGH);
        idx    = int'((a >> (2 + OFFW)) % LINES);
        tg     = int'((a >> CBITS) % (1 << TAGW));
        off    = int'((a >> 2) % LW);
        lbase  = {a[31:2+OFFW], {(OFFW+2){1'b0}}};
        if (!in_win) kind = 2;
        else if (ref_ok[idx] && ref_tag[idx] == tg) kind = 0;
        else kind = 1;
        if (want >= 0) check(kind == want, "R1 R5 R6 expected kind", kind, want);
        start       = req_cnt;
        fetch_valid = 1'b1;
        fetch_addr  = a;
        while (!fetch_ready) @(negedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        lat_c = 1;
        while (!resp_valid && lat_c < 500) begin
            @(negedge clk);
            lat_c++;
        end
        got   = resp_data;
        check(!fetch_ready, "R7 busy at response", fetch_ready, 0);
        extra = 0;
        @(negedge clk);
        while (!fetch_ready && extra < 500) begin
            if (resp_valid) extra++;
            @(negedge clk);
        end
        check(extra == 0, "R7 single response", extra, 0);
        delta = req_cnt - start;
        check(got == memfn(a), kind == 0 ? "R2 hit data" : (kind == 1 ? "R3 miss data" : "R1 bypass data"), got, memfn(a));
        if (kind == 0) begin
            check(lat_c == 1, "R2 hit latency", lat_c, 1);
            check(delta == 0, "R2 no memory request", delta, 0);
        end else if (kind == 1) begin
            check(lat_c > 1, "R3 miss latency", lat_c, 2);
            check(req_log[start % LOGN] == {a[31:2], 2'b00}, "R3 critical word first", req_log[start % LOGN], a);
            check(delta == LW, "R4 fill length", delta, LW);
            for (int i = 1; i < LW; i++) begin
                check(req_log[(start + i) % LOGN] == lbase + 32'(((off + i) % LW) * 4),
                      "R4 wrap order", req_log[(start + i) % LOGN], lbase + 32'(((off + i) % LW) * 4));
            end
            ref_ok[idx]  = 1;
            ref_tag[idx] = tg;
        end else begin
            check(delta == 1, "R1 single bypass request", delta, 1);
            check(req_log[start % LOGN] == a, "R1 bypass address", req_log[start % LOGN], a);
        end
    endtask

    task automatic pulse_inv();
        int n;
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        n = 0;
        while (!fetch_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == LINES + 1, "R6 sweep length", n, LINES + 1);
        for (int i = 0; i < LINES; i++) ref_ok[i] = 0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a;
        int          r;
        void'($urandom(32'd24680));
        for (int i = 0; i < LINES; i++) begin
            ref_ok[i]  = 0;
            ref_tag[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fetch_ready === 1'b1, "R9 ready after reset", fetch_ready, 1);
        check(resp_valid === 1'b0, "R9 no response after reset", resp_valid, 0);
        check(mem_req_valid === 1'b0, "R9 no request after reset", mem_req_valid, 0);

        do_fetch(BASE, 1);                 // R9 cold miss
        do_fetch(BASE + 32'h4, 0);         // R2
        do_fetch(BASE + 32'h1C, 0);        // R4 last word of filled line
        do_fetch(BASE + 32'h114, 1);       // R4 mid-line critical word, wraps
        do_fetch(BASE + 32'h108, 0);
        do_fetch(HIGH - 32'h3, 1);         // R1 top word is cacheable
        do_fetch(HIGH + 32'h1, 2);         // R1 above window
        do_fetch(HIGH + 32'h1, 2);         // R1 not allocated
        do_fetch(BASE - 32'h4, 2);         // R1 below window
        do_fetch(BASE + 32'h40, 1);        // R5 conflict set
        do_fetch(BASE + 32'h440, 1);
        do_fetch(BASE + 32'h40, 1);        // R5 evicted
        do_fetch(BASE + 32'h44, 0);
        pulse_inv();                       // R6
        do_fetch(BASE + 32'h44, 1);        // R6 miss after sweep
        do_fetch(HIGH - 32'h3, 1);

        for (int k = 0; k < 250; k++) begin
            r = int'($urandom % 10);
            if (r < 7)      a = BASE + 32'(($urandom % 3) * 1024) + 32'(($urandom % 64) * 4);
            else if (r < 9) a = BASE + 32'(($urandom % 16384) * 4);
            else if ($urandom % 2 == 0) a = HIGH + 32'h1 + 32'(($urandom % 64) * 4);
            else            a = BASE - 32'h4 - 32'(($urandom % 64) * 4);
            do_fetch(a, -1);
            if (k == 125) pulse_inv();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule